// File: doc/BRIEF.md
# UART FIFO Control and Line Status

This block sits between the host bus and the serial shift logic of a 16550-style UART. It holds a transmit byte queue and a receive queue whose entries carry error tags. A write-only control word turns queueing on or off and can flush either queue. From the contents of the queues it derives the line-status bits and the two interrupt causes. The transmit and receive shifters live outside the block and reach it only through pop and push strobes. A flush therefore never touches a byte that a shifter has already taken.

In queued mode each direction buffers up to `DEPTH` entries. In unqueued mode each direction acts as a one-byte holding register and reports through the same status flags. Overrun, parity, framing and break are sticky flags. A line-status read clears them. A receive flush does not clear them.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After a synchronous reset the block is in unqueued mode, both queues are empty, `tx_req` is 1, and `data_ready`, `fifo_err`, all four sticky flags and both interrupt causes are 0.
- R2: A control write with bit 0 = 1 selects queued mode. A write with bit 0 = 0 selects unqueued mode. Any write that changes the mode empties both queues.
- R3: A control write with bit 0 = 0 empties both queues even when the mode does not change. Bits 1 and 2 of that write are ignored.
- R4: A control write with bits 0 and 2 both set empties the transmit queue, so `tx_req` goes to 1. `irq_tx_req` then follows if `tx_int_en` is 1.
- R5: A control write with bits 0 and 1 both set empties the receive queue. This clears `data_ready`, every stored error tag, `fifo_err` and a pending `irq_rx_avail`.
- R6: A receive flush leaves `oe_flag`, `pe_flag`, `fe_flag` and `bi_flag` unchanged.
- R7: A control write with bits 1 and 2 at 0 and bit 0 = 1, issued while already in queued mode, leaves both queues as they were.
- R8: Capacity is `DEPTH` in queued mode and 1 in unqueued mode. A receive push into a full queue drops the byte and sets `oe_flag`. A transmit write into a full queue is dropped, and `thr_full` reports that the queue is full.
- R9: Both queues return bytes in arrival order. `rbr_rdata` and `tx_data` show the oldest entry.
- R10: `fifo_err` is 1 exactly when at least one stored receive entry carries a parity, framing or break tag.
- R11: An accepted receive push with a tag sets the matching sticky flag. The flags clear only on `lsr_rd`. A set in the same cycle wins over the clear.
- R12: `irq_rx_avail` equals `rx_int_en` AND `data_ready`. `irq_tx_req` equals `tx_int_en` AND `tx_req`.
- R13: A flush takes precedence over a push or pop to the same queue in the same cycle. The push is discarded and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcr_we | input | 1 | Control word write strobe |
| fcr_wdata | input | 3 | Control word: bit0 enable, bit1 receive flush, bit2 transmit flush |
| tx_int_en | input | 1 | Transmit-request interrupt enable |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| thr_we | input | 1 | Host writes a byte to the transmit queue |
| thr_wdata | input | 8 | Byte to transmit |
| thr_full | output | 1 | Transmit queue cannot accept a byte |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_data_in | input | 8 | Received byte |
| rx_pe_in | input | 1 | Parity error tag of the received byte |
| rx_fe_in | input | 1 | Framing error tag of the received byte |
| rx_bi_in | input | 1 | Break tag of the received byte |
| rbr_re | input | 1 | Host reads the oldest received byte |
| rbr_rdata | output | 8 | Oldest received byte |
| lsr_rd | input | 1 | Line-status read, clears sticky flags |
| fifo_mode | output | 1 | 1 in queued mode |
| data_ready | output | 1 | Receive queue holds a byte |
| tx_req | output | 1 | Transmit queue is empty |
| fifo_err | output | 1 | Some stored receive entry carries an error tag |
| oe_flag | output | 1 | Sticky overrun |
| pe_flag | output | 1 | Sticky parity error |
| fe_flag | output | 1 | Sticky framing error |
| bi_flag | output | 1 | Sticky break |
| irq_rx_avail | output | 1 | Received-data-available interrupt cause |
| irq_tx_req | output | 1 | Transmit-request interrupt cause |

## Verification
The bench builds the block with `DEPTH` = 4. With that depth, random receive traffic fills the queue within a few cycles. Overrun in queued mode, full-queue drops and pointer wrap-around therefore all occur many times in a short run, not only on a 64-entry boundary. Random control writes, including writes with bit 0 clear, land between pushes and pops. This exercises mode changes, same-cycle flush against push, and flushes that find tagged entries present.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int FCR_EN    = 0;
    localparam int FCR_RXRST = 1;
    localparam int FCR_TXRST = 2;
    localparam int FCR_W     = 3;

    typedef struct packed {
        logic       bi;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

    function automatic logic entry_has_err(rx_entry_t e);
        return e.bi | e.fe | e.pe;
    endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_acc, pop_acc;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty    = (count == '0);
        full     = single ? !empty : (count == CW'(DEPTH));
        push_acc = push && !full && !flush;
        pop_acc  = pop && !empty && !flush;
        head     = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= bump(wr_ptr);
            if (pop_acc)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_acc) - CW'(pop_acc);
        end
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/ufc_fcr.sv
module ufc_fcr
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [FCR_W-1:0] wdata,
    output logic             mode,
    output logic             flush_rx,
    output logic             flush_tx
);
    always_comb begin
        flush_rx = we && (!wdata[FCR_EN] || !mode || wdata[FCR_RXRST]);
        flush_tx = we && (!wdata[FCR_EN] || !mode || wdata[FCR_TXRST]);
    end

    always_ff @(posedge clk) begin
        if (rst)     mode <= 1'b0;
        else if (we) mode <= wdata[FCR_EN];
    end
endmodule

// File: rtl/ufc_status.sv
module ufc_status
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush_rx,
    input  logic      rx_full,
    input  logic      rx_empty,
    input  logic      rx_push,
    input  rx_entry_t push_entry,
    input  logic      rx_pop,
    input  rx_entry_t head_entry,
    input  logic      lsr_rd,
    output logic      fifo_err,
    output logic      oe,
    output logic      pe,
    output logic      fe,
    output logic      bi
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] err_cnt;
    logic          acc_push, acc_pop, inc, dec, ovr;

    always_comb begin
        acc_push = rx_push && !rx_full && !flush_rx;
        acc_pop  = rx_pop && !rx_empty && !flush_rx;
        inc      = acc_push && entry_has_err(push_entry);
        dec      = acc_pop && entry_has_err(head_entry);
        ovr      = rx_push && rx_full && !flush_rx;
        fifo_err = (err_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush_rx) err_cnt <= '0;
        else                 err_cnt <= err_cnt + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe <= 1'b0;
            pe <= 1'b0;
            fe <= 1'b0;
            bi <= 1'b0;
        end else begin
            oe <= (oe && !lsr_rd) || ovr;
            pe <= (pe && !lsr_rd) || (acc_push && push_entry.pe);
            fe <= (fe && !lsr_rd) || (acc_push && push_entry.fe);
            bi <= (bi && !lsr_rd) || (acc_push && push_entry.bi);
        end
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fcr_we,
    input  logic [2:0] fcr_wdata,
    input  logic       tx_int_en,
    input  logic       rx_int_en,
    input  logic       thr_we,
    input  logic [7:0] thr_wdata,
    output logic       thr_full,
    input  logic       tx_pop,
    output logic [7:0] tx_data,
    input  logic       rx_push,
    input  logic [7:0] rx_data_in,
    input  logic       rx_pe_in,
    input  logic       rx_fe_in,
    input  logic       rx_bi_in,
    input  logic       rbr_re,
    output logic [7:0] rbr_rdata,
    input  logic       lsr_rd,
    output logic       fifo_mode,
    output logic       data_ready,
    output logic       tx_req,
    output logic       fifo_err,
    output logic       oe_flag,
    output logic       pe_flag,
    output logic       fe_flag,
    output logic       bi_flag,
    output logic       irq_rx_avail,
    output logic       irq_tx_req
);
    logic      flush_rx, flush_tx;
    logic      rx_full, rx_empty, tx_empty;
    rx_entry_t in_entry, head_entry;

    always_comb begin
        in_entry.data = rx_data_in;
        in_entry.pe   = rx_pe_in;
        in_entry.fe   = rx_fe_in;
        in_entry.bi   = rx_bi_in;
    end

    ufc_fcr u_fcr (
        .clk(clk), .rst(rst), .we(fcr_we), .wdata(fcr_wdata),
        .mode(fifo_mode), .flush_rx(flush_rx), .flush_tx(flush_tx)
    );

    ufc_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx), .single(!fifo_mode),
        .push(thr_we), .push_data(thr_wdata), .pop(tx_pop),
        .head(tx_data), .full(thr_full), .empty(tx_empty)
    );

    ufc_fifo #(.W(RX_ENTRY_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx), .single(!fifo_mode),
        .push(rx_push), .push_data(in_entry), .pop(rbr_re),
        .head(head_entry), .full(rx_full), .empty(rx_empty)
    );

    ufc_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst(rst), .flush_rx(flush_rx), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_push(rx_push), .push_entry(in_entry),
        .rx_pop(rbr_re), .head_entry(head_entry), .lsr_rd(lsr_rd),
        .fifo_err(fifo_err), .oe(oe_flag), .pe(pe_flag), .fe(fe_flag),
        .bi(bi_flag)
    );

    always_comb begin
        rbr_rdata    = head_entry.data;
        data_ready   = !rx_empty;
        tx_req       = tx_empty;
        irq_rx_avail = rx_int_en && data_ready;
        irq_tx_req   = tx_int_en && tx_req;
    end
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker (
    input logic       clk,
    input logic       rst,
    input logic       fcr_we,
    input logic [2:0] fcr_wdata,
    input logic       lsr_rd,
    input logic       rx_int_en,
    input logic       fifo_mode,
    input logic       data_ready,
    input logic       tx_req,
    input logic       fifo_err,
    input logic       oe_flag,
    input logic       irq_rx_avail
);
    assert_disable_flush_R3: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && !fcr_wdata[0]) |=> (!fifo_mode && !data_ready && tx_req));

    assert_tx_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && fcr_wdata[0] && fcr_wdata[2]) |=> tx_req);

    assert_rx_reset_R5: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && fcr_wdata[0] && fcr_wdata[1]) |=> (!data_ready && !fifo_err && !irq_rx_avail));

    assert_sticky_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && fcr_wdata[1] && oe_flag && !lsr_rd) |=> oe_flag);

    assert_err_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_err |-> data_ready);

    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (rst)
        (!rx_int_en) |-> !irq_rx_avail);
endmodule

bind uart_fifo_ctl ufc_checker i_chk (
    .clk(clk), .rst(rst), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .lsr_rd(lsr_rd), .rx_int_en(rx_int_en), .fifo_mode(fifo_mode),
    .data_ready(data_ready), .tx_req(tx_req), .fifo_err(fifo_err),
    .oe_flag(oe_flag), .irq_rx_avail(irq_rx_avail)
);

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;
    localparam int DEPTH = 4;

    logic clk = 0, rst = 1;
    logic fcr_we = 0; logic [2:0] fcr_wdata = 0;
    logic tx_int_en = 0, rx_int_en = 0;
    logic thr_we = 0; logic [7:0] thr_wdata = 0;
    logic thr_full, tx_pop = 0; logic [7:0] tx_data;
    logic rx_push = 0; logic [7:0] rx_data_in = 0;
    logic rx_pe_in = 0, rx_fe_in = 0, rx_bi_in = 0;
    logic rbr_re = 0; logic [7:0] rbr_rdata;
    logic lsr_rd = 0;
    logic fifo_mode, data_ready, tx_req, fifo_err;
    logic oe_flag, pe_flag, fe_flag, bi_flag, irq_rx_avail, irq_tx_req;

    int checks = 0, errors = 0;

    // reference model state
    logic [10:0] m_rx[$];
    logic [7:0]  m_tx[$];
    bit m_mode, m_oe, m_pe, m_fe, m_bi;

    always #10 clk = ~clk;

    uart_fifo_ctl #(.DEPTH(DEPTH)) i_uart_fifo_ctl (
        .clk(clk), .rst(rst), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .tx_int_en(tx_int_en), .rx_int_en(rx_int_en),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_full(thr_full),
        .tx_pop(tx_pop), .tx_data(tx_data),
        .rx_push(rx_push), .rx_data_in(rx_data_in), .rx_pe_in(rx_pe_in),
        .rx_fe_in(rx_fe_in), .rx_bi_in(rx_bi_in),
        .rbr_re(rbr_re), .rbr_rdata(rbr_rdata), .lsr_rd(lsr_rd),
        .fifo_mode(fifo_mode), .data_ready(data_ready), .tx_req(tx_req),
        .fifo_err(fifo_err), .oe_flag(oe_flag), .pe_flag(pe_flag),
        .fe_flag(fe_flag), .bi_flag(bi_flag),
        .irq_rx_avail(irq_rx_avail), .irq_tx_req(irq_tx_req)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_err();
        foreach (m_rx[i]) if (m_rx[i][10:8] != 0) return 1;
        return 0;
    endfunction

    task automatic idle();
        fcr_we = 0; fcr_wdata = 0; thr_we = 0; tx_pop = 0;
        rx_push = 0; rx_pe_in = 0; rx_fe_in = 0; rx_bi_in = 0;
        rbr_re = 0; lsr_rd = 0;
    endtask

    task automatic model_update();
        bit frx, ftx, ovr;
        int cap, pre;
        logic [10:0] ent;
        frx = fcr_we && (!fcr_wdata[0] || !m_mode || fcr_wdata[1]);
        ftx = fcr_we && (!fcr_wdata[0] || !m_mode || fcr_wdata[2]);
        cap = m_mode ? DEPTH : 1;
        if (ftx) m_tx.delete();
        else begin
            pre = m_tx.size();
            if (tx_pop && pre > 0) void'(m_tx.pop_front());
            if (thr_we && pre < cap) m_tx.push_back(thr_wdata);
        end
        ovr = 0;
        ent = {rx_bi_in, rx_fe_in, rx_pe_in, rx_data_in};
        if (lsr_rd) begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
        if (frx) m_rx.delete();
        else begin
            pre = m_rx.size();
            if (rbr_re && pre > 0) void'(m_rx.pop_front());
            if (rx_push && pre < cap) begin
                m_rx.push_back(ent);
                if (rx_pe_in) m_pe = 1;
                if (rx_fe_in) m_fe = 1;
                if (rx_bi_in) m_bi = 1;
            end else if (rx_push) ovr = 1;
        end
        if (ovr) m_oe = 1;
        if (fcr_we) m_mode = fcr_wdata[0];
    endtask

    task automatic compare();
        int cap;
        cap = m_mode ? DEPTH : 1;
        chk("R2 mode", fifo_mode, m_mode);
        chk("R8 data_ready", data_ready, m_rx.size() != 0);
        chk("R4 tx_req", tx_req, m_tx.size() == 0);
        chk("R8 thr_full", thr_full, m_tx.size() >= cap);
        chk("R10 fifo_err", fifo_err, exp_err());
        chk("R8 oe", oe_flag, m_oe);
        chk("R11 pe", pe_flag, m_pe);
        chk("R11 fe", fe_flag, m_fe);
        chk("R11 bi", bi_flag, m_bi);
        chk("R12 irq_rx", irq_rx_avail, rx_int_en && m_rx.size() != 0);
        chk("R12 irq_tx", irq_tx_req, tx_int_en && m_tx.size() == 0);
        if (m_rx.size() != 0) chk("R9 rx head", rbr_rdata, m_rx[0][7:0]);
        if (m_tx.size() != 0) chk("R9 tx head", tx_data, m_tx[0]);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic fcr(logic [2:0] d);
        fcr_we = 1; fcr_wdata = d; step();
    endtask

    task automatic rxp(logic [7:0] d, logic [2:0] tags);
        rx_push = 1; rx_data_in = d; {rx_bi_in, rx_fe_in, rx_pe_in} = tags; step();
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_mode = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        // R1 reset state
        chk("R1 mode", fifo_mode, 0);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 status", {data_ready, fifo_err, oe_flag, pe_flag, fe_flag, bi_flag,
                          irq_rx_avail, irq_tx_req}, 0);

        // R8 unqueued capacity of one: second push overruns
        rxp(8'h11, 0); rxp(8'h22, 0);
        chk("R8 single overrun", oe_flag, 1);
        chk("R8 single keeps first", rbr_rdata, 8'h11);
        lsr_rd = 1; step();
        chk("R11 lsr_rd clears", oe_flag, 0);

        // R2 enter queued mode, previous byte flushed
        fcr(3'b001);
        chk("R2 mode on", fifo_mode, 1);
        chk("R2 change flushes", data_ready, 0);

        // R9 order, R8 overrun at DEPTH, R10 tags
        rx_int_en = 1; tx_int_en = 1;
        for (int i = 0; i < DEPTH + 1; i++) rxp(8'hA0 + 8'(i), (i == 1) ? 3'b001 : 3'b000);
        chk("R8 queued overrun", oe_flag, 1);
        chk("R10 tag present", fifo_err, 1);
        rbr_re = 1; step();
        chk("R9 second byte", rbr_rdata, 8'hA1);

        // R7 control write without reset bits keeps contents
        fcr(3'b001);
        chk("R7 kept", rbr_rdata, 8'hA1);

        // R13 flush beats same-cycle push; R5 and R6
        rx_push = 1; rx_data_in = 8'h55; rx_fe_in = 1; fcr(3'b011);
        chk("R13 push dropped", data_ready, 0);
        chk("R13 no flag", fe_flag, 0);
        chk("R5 irq cleared", irq_rx_avail, 0);
        chk("R5 err cleared", fifo_err, 0);
        chk("R6 overrun kept", oe_flag, 1);
        chk("R6 parity kept", pe_flag, 1);

        // R4 transmit flush raises request
        thr_we = 1; thr_wdata = 8'h3C; step();
        chk("R4 tx pending", tx_req, 0);
        fcr(3'b101);
        chk("R4 tx flushed", tx_req, 1);
        chk("R4 irq_tx", irq_tx_req, 1);

        // R3 bit0 clear ignores other bits, still flushes
        rxp(8'h77, 0);
        fcr(3'b110);
        chk("R3 mode off", fifo_mode, 0);
        chk("R3 flushed", data_ready, 0);
        rxp(8'h78, 0);
        fcr(3'b000);
        chk("R3 flush same mode", data_ready, 0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            fcr_we     = ($urandom % 20) == 0;
            fcr_wdata  = 3'($urandom);
            if (($urandom % 5) != 0) fcr_wdata[0] = 1;
            thr_we     = ($urandom % 2) == 0;
            thr_wdata  = 8'($urandom);
            tx_pop     = ($urandom % 3) == 0;
            rx_push    = ($urandom % 2) == 0;
            rx_data_in = 8'($urandom);
            rx_pe_in   = ($urandom % 6) == 0;
            rx_fe_in   = ($urandom % 6) == 0;
            rx_bi_in   = ($urandom % 6) == 0;
            rbr_re     = ($urandom % 3) == 0;
            lsr_rd     = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) rx_int_en = ~rx_int_en;
            if (($urandom % 16) == 0) tx_int_en = ~tx_int_en;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule